// File: doc/BRIEF.md
# Dual-Select Static Word Memory

This block is a clocked, synthesizable model of a small static memory holding 256 words of 4 bits each. It has a separate write-data input and a separate read-data output. Four control pins choose what it does in each cycle: an active-low select, an active-high select, an active-low write strobe and an active-low output gate. From these the block enters one of four modes: idle, muted, reading or writing. A real three-state pin cannot be synthesized, so the read bus is split into a data value and an explicit drive flag. The data value is zero whenever the drive flag is low.

The cells sit in a 32 by 32 bit array. The upper five address bits pick the row. The lower three bits pick one of the eight 4-bit groups inside that row. A write is stored at the rising clock edge of every cycle in which the write condition holds. A read is combinational from the present address and the stored contents. Because of this, a word written in one cycle is visible on the outputs in the very next cycle, with no recovery gap. A synchronous active-low reset holds the outputs quiet and blocks writes. It does not clear the stored cells.

Top module: `qsram_top`

## Requirements
- R1: Each of the 256 addresses holds its own 4-bit word. Row is address bits 7:3 and group is address bits 2:0. Writing one address leaves every other address unchanged, including the neighbours in the same row and the same group in other rows.
- R2: When `sel_lo_n` is 1 or `sel_hi` is 0, the block is idle: `rd_en` is 0 and a low `wr_n` stores nothing.
- R3: When `sel_lo_n` is 0, `sel_hi` is 1 and `wr_n` is 0 at a rising clock edge with reset released, `wr_data` is stored at `addr`, whatever the value of `oe_n`.
- R4: In any cycle in which the write condition of R3 holds, `rd_en` is 0.
- R5: When `sel_lo_n` is 0, `sel_hi` is 1, `wr_n` is 1 and `oe_n` is 0, `rd_en` is 1 and `rd_data` equals the stored word at the present `addr`, bit for bit and not inverted, in the same cycle.
- R6: When the block is selected with `wr_n` at 1 and `oe_n` at 1, `rd_en` is 0 and the stored contents do not change.
- R7: `rd_data` is 0 in every cycle in which `rd_en` is 0.
- R8: A read of an address in the cycle right after a write to it returns the newly written word.
- R9: While `rst_n` is 0, `rd_en` is 0 and writes are ignored. Contents written before reset survive it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; writes are stored on its rising edge |
| rst_n | input | 1 | Active-low reset; quiets outputs and blocks writes |
| addr | input | 8 | Word address (row in bits 7:3, group in bits 2:0) |
| wr_data | input | 4 | Data to be written |
| sel_lo_n | input | 1 | Active-low select |
| sel_hi | input | 1 | Active-high select |
| wr_n | input | 1 | Active-low write strobe |
| oe_n | input | 1 | Active-low output gate |
| rd_data | output | 4 | Read word; zero when not driving |
| rd_en | output | 1 | High when `rd_data` is actively driven |

## Verification
The checker covers the control decode on every cycle. It confirms that the idle selects, a write and a high output gate each keep `rd_en` low, and that a valid read raises it. It also confirms that an undriven bus reads zero and that reset keeps the bus quiet. It further checks that a read right after a write to the same address returns the written word. The bench scenarios are needed to show storage itself. These include a full sweep of all 256 addresses, writes blocked while idle or in reset, and the isolation of neighbouring words in one row.

// File: rtl/qsram_pkg.sv
package qsram_pkg;

    typedef enum logic [1:0] {
        QS_IDLE  = 2'd0,
        QS_MUTE  = 2'd1,
        QS_READ  = 2'd2,
        QS_WRITE = 2'd3
    } qs_mode_e;

endpackage

// File: rtl/qsram_mode.sv
module qsram_mode
    import qsram_pkg::*;
(
    input  logic     rst_n,
    input  logic     sel_lo_n,
    input  logic     sel_hi,
    input  logic     wr_n,
    input  logic     oe_n,
    output qs_mode_e mode
);

    always_comb begin
        if (!rst_n || sel_lo_n || !sel_hi) begin
            mode = QS_IDLE;
        end else if (!wr_n) begin
            mode = QS_WRITE;
        end else if (!oe_n) begin
            mode = QS_READ;
        end else begin
            mode = QS_MUTE;
        end
    end

endmodule

// File: rtl/qsram_decode.sv
module qsram_decode #(
    parameter int ROW_W  = 5,
    parameter int GRP_W  = 3,
    parameter int ADDR_W = ROW_W + GRP_W
) (
    input  logic [ADDR_W-1:0] addr,
    output logic [ROW_W-1:0]  row,
    output logic [GRP_W-1:0]  grp
);

    // Upper bits select the row, lower bits the column group.
    assign row = addr[ADDR_W-1 -: ROW_W];

    generate
        if (GRP_W > 0) begin : g_split
            assign grp = addr[GRP_W-1:0];
        end else begin : g_single
            assign grp = '0;
        end
    endgenerate

endmodule

// File: rtl/qsram_array.sv
module qsram_array #(
    parameter int ROWS  = 32,
    parameter int COLS  = 32,
    parameter int WIDTH = 4,
    parameter int ROW_W = $clog2(ROWS),
    parameter int GRP_W = $clog2(COLS / WIDTH)
) (
    input  logic             clk,
    input  logic             wr_en,
    input  logic [ROW_W-1:0] row,
    input  logic [GRP_W-1:0] grp,
    input  logic [WIDTH-1:0] wr_data,
    output logic [WIDTH-1:0] rd_word
);

    typedef struct packed {
        logic [ROWS-1:0][COLS-1:0] cells;
    } array_t;

    array_t state_d;
    array_t state_q;

    always_comb begin
        state_d = state_q;
        if (wr_en) begin
            state_d.cells[row][int'(grp) * WIDTH +: WIDTH] = wr_data;
        end
    end

    // Contents are deliberately not reset.
    always_ff @(posedge clk) begin
        state_q <= state_d;
    end

    assign rd_word = state_q.cells[row][int'(grp) * WIDTH +: WIDTH];

endmodule

// File: rtl/qsram_top.sv
module qsram_top
    import qsram_pkg::*;
#(
    parameter int ROWS   = 32,
    parameter int COLS   = 32,
    parameter int WIDTH  = 4,
    parameter int ADDR_W = $clog2(ROWS) + $clog2(COLS / WIDTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [WIDTH-1:0]  wr_data,
    input  logic              sel_lo_n,
    input  logic              sel_hi,
    input  logic              wr_n,
    input  logic              oe_n,
    output logic [WIDTH-1:0]  rd_data,
    output logic              rd_en
);

    localparam int GROUPS = COLS / WIDTH;
    localparam int ROW_W  = $clog2(ROWS);
    localparam int GRP_W  = $clog2(GROUPS);

    qs_mode_e         mode;
    logic [ROW_W-1:0] row;
    logic [GRP_W-1:0] grp;
    logic [WIDTH-1:0] word;

    qsram_mode u_mode (
        .rst_n    (rst_n),
        .sel_lo_n (sel_lo_n),
        .sel_hi   (sel_hi),
        .wr_n     (wr_n),
        .oe_n     (oe_n),
        .mode     (mode)
    );

    qsram_decode #(
        .ROW_W  (ROW_W),
        .GRP_W  (GRP_W),
        .ADDR_W (ADDR_W)
    ) u_decode (
        .addr (addr),
        .row  (row),
        .grp  (grp)
    );

    qsram_array #(
        .ROWS  (ROWS),
        .COLS  (COLS),
        .WIDTH (WIDTH),
        .ROW_W (ROW_W),
        .GRP_W (GRP_W)
    ) u_array (
        .clk     (clk),
        .wr_en   (mode == QS_WRITE),
        .row     (row),
        .grp     (grp),
        .wr_data (wr_data),
        .rd_word (word)
    );

    assign rd_en   = (mode == QS_READ);
    assign rd_data = rd_en ? word : '0;

endmodule

// File: rtl/qsram_checker.sv
module qsram_checker #(
    parameter int ADDR_W = 8,
    parameter int WIDTH  = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] addr,
    input logic [WIDTH-1:0]  wr_data,
    input logic              sel_lo_n,
    input logic              sel_hi,
    input logic              wr_n,
    input logic              oe_n,
    input logic [WIDTH-1:0]  rd_data,
    input logic              rd_en
);

    logic picked;
    logic wr_cond;
    logic rd_cond;

    assign picked  = !sel_lo_n && sel_hi;
    assign wr_cond = picked && !wr_n;
    assign rd_cond = picked && wr_n && !oe_n;

    a_r2_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_lo_n || !sel_hi) |-> !rd_en);

    a_r4_write_mutes: assert property (@(posedge clk) disable iff (!rst_n)
        wr_cond |-> !rd_en);

    a_r5_read_drives: assert property (@(posedge clk) disable iff (!rst_n)
        rd_cond |-> rd_en);

    a_r6_gate_mutes: assert property (@(posedge clk) disable iff (!rst_n)
        (picked && wr_n && oe_n) |-> !rd_en);

    a_r7_zero_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |-> (rd_data == '0));

    a_r8_fresh_read: assert property (@(posedge clk) disable iff (!rst_n)
        wr_cond |=> (!(rd_cond && addr == $past(addr)) || rd_data == $past(wr_data)));

    // R9: outputs stay quiet while reset is held
    always @(posedge clk) begin
        if (!rst_n) begin
            a_r9_reset_quiet: assert (!rd_en && rd_data == '0);
        end
    end

endmodule

bind qsram_top qsram_checker #(
    .ADDR_W (ADDR_W),
    .WIDTH  (WIDTH)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .addr     (addr),
    .wr_data  (wr_data),
    .sel_lo_n (sel_lo_n),
    .sel_hi   (sel_hi),
    .wr_n     (wr_n),
    .oe_n     (oe_n),
    .rd_data  (rd_data),
    .rd_en    (rd_en)
);

// File: tb/qsram_top_test.sv
module qsram_top_test;

    logic       clk = 1'b0;
    logic       rst_n;
    logic [7:0] addr;
    logic [3:0] wr_data;
    logic       sel_lo_n;
    logic       sel_hi;
    logic       wr_n;
    logic       oe_n;
    logic [3:0] rd_data;
    logic       rd_en;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;
    logic [3:0] model [256];

    always #5 clk = ~clk;

    qsram_top uut (
        .clk      (clk),
        .rst_n    (rst_n),
        .addr     (addr),
        .wr_data  (wr_data),
        .sel_lo_n (sel_lo_n),
        .sel_hi   (sel_hi),
        .wr_n     (wr_n),
        .oe_n     (oe_n),
        .rd_data  (rd_data),
        .rd_en    (rd_en)
    );

    function automatic logic [3:0] pat(int a, int k);
        return 4'((a ^ (a >> 4) ^ (a * 3) ^ k) & 15);
    endfunction

    task automatic check(string req, logic [4:0] act, logic [4:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Drive one cycle at the falling edge, sample 1 ns later, then let the rising edge pass.
    task automatic drive(logic s1n, logic s2, logic w, logic o, int a, logic [3:0] d);
        @(negedge clk);
        sel_lo_n = s1n; sel_hi = s2; wr_n = w; oe_n = o;
        addr = 8'(a); wr_data = d;
        #1;
    endtask

    task automatic read_check(string req, int a);
        drive(1'b0, 1'b1, 1'b1, 1'b0, a, 4'h0);
        check(req, {rd_en, rd_data}, {1'b1, model[a]});
    endtask

    initial begin
        rst_n = 1'b0; sel_lo_n = 1'b1; sel_hi = 1'b0; wr_n = 1'b1; oe_n = 1'b1;
        addr = '0; wr_data = '0;
        repeat (3) @(posedge clk);
        #1;
        // R9: reset state, even with read controls applied
        drive(1'b0, 1'b1, 1'b1, 1'b0, 0, 4'h0);
        check("R9 reset quiet", {rd_en, rd_data}, 5'h00);
        @(negedge clk);
        rst_n = 1'b1;

        // R3/R4: fill every address, output gate alternating
        for (int a = 0; a < 256; a++) begin
            drive(1'b0, 1'b1, 1'b0, a[0], a, pat(a, 0));
            model[a] = pat(a, 0);
            check("R4 write mutes", {rd_en, rd_data}, 5'h00);
        end
        // R1/R3/R5: read back all addresses
        for (int a = 0; a < 256; a++) read_check("R5 R3 R1 sweep", a);

        // R2: attempts while idle by either select store nothing
        for (int a = 0; a < 256; a += 17) begin
            drive(1'b1, 1'b1, 1'b0, 1'b0, a, ~model[a]);
            check("R2 idle lo", {rd_en, rd_data}, 5'h00);
            drive(1'b0, 1'b0, 1'b0, 1'b0, a, ~model[a]);
            check("R2 idle hi", {rd_en, rd_data}, 5'h00);
            read_check("R2 unchanged", a);
        end

        // R6/R7: output gate high mutes and changes nothing
        for (int a = 3; a < 256; a += 29) begin
            drive(1'b0, 1'b1, 1'b1, 1'b1, a, ~model[a]);
            check("R6 R7 gate mutes", {rd_en, rd_data}, 5'h00);
            read_check("R6 unchanged", a);
        end

        // R8: read immediately after write returns the new word
        for (int a = 5; a < 256; a += 23) begin
            drive(1'b0, 1'b1, 1'b0, 1'b0, a, pat(a, 9));
            model[a] = pat(a, 9);
            read_check("R8 fresh read", a);
        end

        // R1: isolation of neighbours in the row and same group in other rows
        drive(1'b0, 1'b1, 1'b0, 1'b1, 8'h25, ~model[8'h25]);
        model[8'h25] = ~model[8'h25];
        read_check("R1 target", 8'h25);
        read_check("R1 row left", 8'h24);
        read_check("R1 row right", 8'h26);
        read_check("R1 other row", 8'h2D);
        read_check("R1 prev row", 8'h1D);

        // R9: writes during reset ignored, contents survive
        @(negedge clk);
        rst_n = 1'b0;
        drive(1'b0, 1'b1, 1'b0, 1'b0, 8'h40, ~model[8'h40]);
        check("R9 reset blocks", {rd_en, rd_data}, 5'h00);
        drive(1'b0, 1'b1, 1'b1, 1'b0, 8'h40, 4'h0);
        check("R9 reset read quiet", {rd_en, rd_data}, 5'h00);
        @(negedge clk);
        rst_n = 1'b1;
        read_check("R9 contents kept", 8'h40);
        read_check("R9 contents kept", 8'hFF);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule